// File: doc/BRIEF.md
# Dual-Rate Parallel-to-Serial Word Shifter

This block turns 10-bit parallel words into a serial bit stream on one bit-rate clock. The byte clock of the word source is not used as a clock. It arrives as two single-cycle strobes, one for its rising edge and one for its falling edge. A rate select picks between two modes:

- **Full rate:** a word is taken on every byte-clock edge and each bit lasts one bit-clock cycle.
- **Half rate:** only the falling edge carries a word and each bit is stretched over two cycles.

A one-word holding stage absorbs a word that arrives while the previous word is still being shifted. That word then follows the last bit of the current word with no gap.

A wrap select steers the stream to an internal loopback output and parks the external line at logic 1. In normal operation the external line carries the stream and the loopback output rests at 1. Whenever no word is being shifted, the stream idles at logic 1.

Top module: `ddr_word_serializer`

## Requirements
- R1: While reset is asserted, and after it is released, both serial outputs are 1. No word captured before or during reset is ever emitted.
- R2: Each word leaves least significant bit first: bit 0 first and bit 9 last. A K28.5 word with bit9..bit0 = 0101111100 therefore appears on the line as 0,0,1,1,1,1,1,0,1,0.
- R3: With full_rate = 1, both a rise strobe and a fall strobe capture word_in. Each bit lasts one cycle, so strobes spaced 10 cycles apart give a stream with no gap.
- R4: With full_rate = 0, only the fall strobe captures, and a rise strobe alone has no effect on either output. Each bit lasts two cycles, so fall strobes spaced 20 cycles apart give a stream with no gap.
- R5: When the shifter is idle, a capturing strobe makes bit 0 of the captured word appear in the very next cycle.
- R6: A word captured while another is still shifting waits in a one-word holding stage. It starts in the cycle after the last bit of the current word. If a new word is captured in the same cycle that the held word is launched, the new word is held in turn.
- R7: Whenever no word is being shifted, both outputs are 1.
- R8: With wrap_en = 0, ser_out carries the stream and loop_out stays 1.
- R9: With wrap_en = 1, ser_out stays 1 and loop_out carries the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| word_in | input | 10 | Parallel word to serialize |
| bclk_rise | input | 1 | One-cycle strobe marking a rising byte-clock edge |
| bclk_fall | input | 1 | One-cycle strobe marking a falling byte-clock edge |
| full_rate | input | 1 | 1: capture on both edges, 1 cycle per bit; 0: capture on the falling edge only, 2 cycles per bit |
| wrap_en | input | 1 | 1: stream goes to loop_out and ser_out is held at 1 |
| ser_out | output | 1 | External serial line |
| loop_out | output | 1 | Internal loopback serial line |

## Verification
The holding stage is hard to reach from the ports. A source that strobes on a regular byte clock always delivers its next word exactly at a word boundary, so the word loads straight from the input and the holding stage is never used. To reach it, the stimulus breaks the regular spacing in two ways:

- It sends a second strobe four cycles after the first, while the first word is still shifting, so the second word must be held.
- It sends a third strobe on the exact boundary at which the held word launches, which exercises the launch-and-refill case of R6.

A reset asserted while a word is both shifting and held then confirms that neither word is emitted afterwards.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned SER_WORD_W   = 10;
  localparam int unsigned SER_SLOW_DIV = 2;

  typedef enum logic {
    ROUTE_LINE = 1'b0,
    ROUTE_WRAP = 1'b1
  } route_e;
endpackage

// File: rtl/ser_capture.sv
module ser_capture #(
  parameter int unsigned WORD_W = ser_pkg::SER_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              full_rate,
  input  logic              take,
  output logic              pend_vld,
  output logic [WORD_W-1:0] pend_word,
  output logic              hold_vld
);
  logic [WORD_W-1:0] hold_q, hold_n;
  logic              vld_q, vld_n;
  logic              cap;

  // a rise strobe only qualifies when both edges carry words
  assign cap       = bclk_fall | (full_rate & bclk_rise);
  assign pend_vld  = vld_q | cap;
  assign pend_word = vld_q ? hold_q : word_in;
  assign hold_vld  = vld_q;

  always_comb begin
    hold_n = hold_q;
    vld_n  = vld_q;
    if (take) begin
      // held word leaves; a simultaneous capture refills the stage
      vld_n = vld_q & cap;
      if (vld_q & cap) hold_n = word_in;
    end else if (cap) begin
      vld_n  = 1'b1;
      hold_n = word_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      vld_q <= vld_n;
      if (cap) hold_q <= hold_n;
    end
  end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int unsigned WORD_W   = ser_pkg::SER_WORD_W,
  parameter int unsigned SLOW_DIV = ser_pkg::SER_SLOW_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_rate,
  input  logic              pend_vld,
  input  logic [WORD_W-1:0] pend_word,
  output logic              take,
  output logic              busy,
  output logic              stream_bit
);
  localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int unsigned SUB_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [WORD_W-1:0] sh_q, sh_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              busy_q, busy_n;
  logic              last_bit, last_sub, boundary, adv;

  assign last_bit   = (idx_q == IDX_W'(WORD_W - 1));
  assign boundary   = ~busy_q | (last_bit & last_sub);
  assign take       = boundary & pend_vld;
  assign adv        = busy_q & ~take;
  assign busy       = busy_q;
  assign stream_bit = busy_q ? sh_q[0] : 1'b1;

  generate
    if (SLOW_DIV > 1) begin : g_stretch
      logic [SUB_W-1:0] sub_q, sub_n;
      assign last_sub = full_rate | (sub_q == SUB_W'(SLOW_DIV - 1));

      always_comb begin
        sub_n = sub_q;
        if (take || (adv && last_sub)) sub_n = '0;
        else if (adv)                  sub_n = sub_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_n;
      end
    end else begin : g_plain
      assign last_sub = 1'b1;
    end
  endgenerate

  always_comb begin
    sh_n   = sh_q;
    idx_n  = idx_q;
    busy_n = busy_q;
    if (take) begin
      sh_n   = pend_word;
      idx_n  = '0;
      busy_n = 1'b1;
    end else if (adv && last_sub) begin
      if (last_bit) begin
        busy_n = 1'b0;
      end else begin
        idx_n = idx_q + 1'b1;
        sh_n  = sh_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      if (take || adv) begin
        sh_q  <= sh_n;
        idx_q <= idx_n;
      end
    end
  end
endmodule

// File: rtl/ser_route.sv
module ser_route (
  input  logic stream_bit,
  input  logic wrap_en,
  output logic ser_out,
  output logic loop_out
);
  import ser_pkg::*;
  route_e mode;

  assign mode = wrap_en ? ROUTE_WRAP : ROUTE_LINE;

  always_comb begin
    ser_out  = 1'b1;
    loop_out = 1'b1;
    case (mode)
      ROUTE_WRAP: loop_out = stream_bit;
      default:    ser_out  = stream_bit;
    endcase
  end
endmodule

// File: rtl/ddr_word_serializer.sv
module ddr_word_serializer #(
  parameter int unsigned WORD_W   = ser_pkg::SER_WORD_W,
  parameter int unsigned SLOW_DIV = ser_pkg::SER_SLOW_DIV
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              full_rate,
  input  logic              wrap_en,
  output logic              ser_out,
  output logic              loop_out
);
  logic              pend_vld, take, sh_busy, hold_vld, stream_bit;
  logic [WORD_W-1:0] pend_word;

  ser_capture #(.WORD_W(WORD_W)) u_cap (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .word_in   (word_in),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .full_rate (full_rate),
    .take      (take),
    .pend_vld  (pend_vld),
    .pend_word (pend_word),
    .hold_vld  (hold_vld)
  );

  ser_shifter #(.WORD_W(WORD_W), .SLOW_DIV(SLOW_DIV)) u_shift (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .full_rate  (full_rate),
    .pend_vld   (pend_vld),
    .pend_word  (pend_word),
    .take       (take),
    .busy       (sh_busy),
    .stream_bit (stream_bit)
  );

  ser_route u_route (
    .stream_bit (stream_bit),
    .wrap_en    (wrap_en),
    .ser_out    (ser_out),
    .loop_out   (loop_out)
  );
endmodule

// File: rtl/ser_checker.sv
module ser_checker (
  input logic clk,
  input logic rst_n,
  input logic full_rate,
  input logic wrap_en,
  input logic bclk_rise,
  input logic bclk_fall,
  input logic ser_out,
  input logic loop_out,
  input logic busy,
  input logic held
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (ser_out && loop_out);
    end
  end

  // R8
  line_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_out |-> wrap_en);

  // R9
  wrap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_out |-> !wrap_en);

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_out && loop_out));

  // R5
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (bclk_fall || (full_rate && bclk_rise))) |=> busy);

  // R4
  rise_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_rate && bclk_rise && !bclk_fall && !busy && !held) |=> !busy);

  // R4
  half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ser_out) && !full_rate && !wrap_en && $past(!wrap_en)) |=> !ser_out);

  // R6
  held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> busy);
endmodule

bind ddr_word_serializer ser_checker u_chk (
  .clk       (bit_clk),
  .rst_n     (rst_n),
  .full_rate (full_rate),
  .wrap_en   (wrap_en),
  .bclk_rise (bclk_rise),
  .bclk_fall (bclk_fall),
  .ser_out   (ser_out),
  .loop_out  (loop_out),
  .busy      (sh_busy),
  .held      (hold_vld)
);

// File: tb/sim_ddr_word_serializer.sv
module sim_ddr_word_serializer;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] K285 = 10'b0101111100;

  typedef struct {
    int    cyc;
    logic  ser;
    logic  lp;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] word_in;
  logic       bclk_rise, bclk_fall, full_rate, wrap_en;
  logic       ser_out, loop_out;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  ddr_word_serializer u0 (
    .bit_clk   (clk),
    .rst_n     (rst_n),
    .word_in   (word_in),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .full_rate (full_rate),
    .wrap_en   (wrap_en),
    .ser_out   (ser_out),
    .loop_out  (loop_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic gs, input logic gl, input logic es,
                       input logic el, input string req);
    n_cmp++;
    if (gs !== es || gl !== el) begin
      n_bad++;
      $display("FAIL %s cyc %0d: ser/loop got %b%b expected %b%b",
               req, cyc, gs, gl, es, el);
    end
  endtask

  // monitor: pops the entry stamped for the current cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: expectation for cycle %0d never sampled (got %b expected %b)",
               exp_q[0].req, exp_q[0].cyc, ser_out, exp_q[0].ser);
      void'(exp_q.pop_front());
    end
    if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      check(ser_out, loop_out, e.ser, e.lp, e.req);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input int c, input logic b, input logic wr, input string req);
    exp_t e;
    e.cyc = c;
    e.ser = wr ? 1'b1 : b;
    e.lp  = wr ? b : 1'b1;
    e.req = req;
    exp_q.push_back(e);
  endtask

  function automatic logic [9:0] pat(input int i, input int seed);
    if (i == 0) return K285;
    return 10'((i * 613 + seed * 97) ^ (i << 3) ^ seed);
  endfunction

  // regular byte-clock stream; R2/R3/R4/R5 plus routing req
  task automatic stream(input bit full, input bit wr, input int nw,
                        input int seed, input string req);
    int m, per, k0;
    logic [9:0] w[64];
    m   = full ? 1 : 2;
    per = 10 * m;
    for (int i = 0; i < nw; i++) w[i] = pat(i, seed);
    full_rate = full;
    wrap_en   = wr;
    k0 = cyc;
    for (int t = 0; t < nw * per + 4; t++) begin
      int wi, bi;
      bclk_rise = 1'b0;
      bclk_fall = 1'b0;
      word_in   = ~pat(t, seed + 5);
      if (full) begin
        if (t % 10 == 0 && t / 10 < nw) begin
          word_in = w[t / 10];
          if ((t / 10) % 2 == 0) bclk_rise = 1'b1;
          else                   bclk_fall = 1'b1;
        end
      end else begin
        if (t % 20 == 0 && t / 20 < nw) begin
          word_in   = w[t / 20];
          bclk_fall = 1'b1;
        end else if (t % 20 == 10) begin
          bclk_rise = 1'b1;   // must be ignored at half rate
        end
      end
      wi = t / per;
      bi = (t % per) / m;
      push(k0 + t + 1, (wi < nw) ? w[wi][bi] : 1'b1, wr, req);
      tick();
    end
  endtask

  // irregular strobes force the holding stage (R6)
  task automatic early_pair();
    logic [9:0] a, b, c;
    int k0;
    a = 10'h2C5; b = 10'h1A3; c = 10'h35E;
    full_rate = 1'b1;
    wrap_en   = 1'b0;
    k0 = cyc;
    for (int t = 0; t < 34; t++) begin
      bclk_rise = 1'b0;
      bclk_fall = 1'b0;
      word_in   = 10'h3FF ^ 10'(t);
      if (t == 0)  begin word_in = a; bclk_fall = 1'b1; end
      if (t == 4)  begin word_in = b; bclk_rise = 1'b1; end
      if (t == 10) begin word_in = c; bclk_fall = 1'b1; end
      if (t < 10)      push(k0 + t + 1, a[t],      1'b0, "R6");
      else if (t < 20) push(k0 + t + 1, b[t - 10], 1'b0, "R6");
      else if (t < 30) push(k0 + t + 1, c[t - 20], 1'b0, "R6");
      else             push(k0 + t + 1, 1'b1,      1'b0, "R7");
      tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; word_in = '0; bclk_rise = 1'b0; bclk_fall = 1'b0;
    full_rate = 1'b1; wrap_en = 1'b0;
    // R1: reset holds both lines high, even with a strobe present
    tick();
    bclk_fall = 1'b1; word_in = 10'h000;
    tick();
    bclk_fall = 1'b0;
    @(negedge clk); check(ser_out, loop_out, 1'b1, 1'b1, "R1");
    tick(); rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); check(ser_out, loop_out, 1'b1, 1'b1, "R1");
    end
    tick();

    // R2/R3/R5/R8: full rate on the line
    stream(1'b1, 1'b0, 6, 3, "R3");
    // R4/R8: half rate on the line, rise strobes ignored
    stream(1'b0, 1'b0, 4, 11, "R4");
    // R9: wrap at both rates
    stream(1'b1, 1'b1, 5, 21, "R9");
    stream(1'b0, 1'b1, 3, 7, "R9");
    // R2: single K28.5 word, explicit order
    stream(1'b1, 1'b0, 1, 0, "R2");

    // R4: lone rise strobe at half rate does nothing
    full_rate = 1'b0; wrap_en = 1'b0;
    bclk_rise = 1'b1; word_in = 10'h000;
    tick();
    bclk_rise = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk); check(ser_out, loop_out, 1'b1, 1'b1, "R4");
    end
    tick();

    // R6: holding stage and launch-with-refill
    early_pair();

    // R1: reset while a word shifts and another is held
    full_rate = 1'b1;
    bclk_fall = 1'b1; word_in = 10'h000;
    tick();
    bclk_fall = 1'b0; bclk_rise = 1'b1; word_in = 10'h000;
    tick();
    bclk_rise = 1'b0;
    tick();
    rst_n = 1'b0;
    #1 check(ser_out, loop_out, 1'b1, 1'b1, "R1");
    tick();
    rst_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); check(ser_out, loop_out, 1'b1, 1'b1, "R1");
    end

    repeat (3) tick();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule